// File: doc/BRIEF.md
# Sleep-Time Long-Write Supervisor

This block oversees a timed non-volatile write that proceeds while the processor core sleeps. A one-cycle start pulse launches the write, and an internal cycle counter measures how long it lasts. While the write is in progress, the block watches a bank of interrupt sources. Each source has a pending flag, an enable bit and a priority bit, and two global enables (one for high and one for low priority) complete the picture. Any source that is both enabled and flagged ends the write early, whatever the global enables and the priority bit say. The global enables and the priority only decide where the core resumes after the write stops.

When the write ends, normally or early, the block raises a completion strobe for exactly one cycle. Beside the strobe it gives an aborted flag and a two-bit resume code. The resume code says one of four things: the write finished normally, execution continues at the next instruction, execution branches to the high-priority vector, or it branches to the low-priority vector. The block never drives the interrupt flags; they stay set until software clears them. An asynchronous reset ends any write at once.

Top module: `lwt_ctrl`

## Requirements
- R1: A start pulse while the block is idle (busy_o and done_o both low) makes busy_o high after the next rising edge. A start pulse while busy_o or done_o is high has no effect on the timing or result of the write in progress.
- R2: With no enabled source flagged, busy_o stays high for exactly WRITE_CYCLES cycles. done_o is then high for one cycle with aborted_o = 0 and action_o = 2'b00.
- R3: A source whose enable bit is 0 never affects the write, even when its flag is 1.
- R4: If any source has flag and enable both at 1 during a busy cycle, the next cycle has done_o = 1 and aborted_o = 1, for every setting of the priority bits and the global enables.
- R5: On an abort with glb_hi_en_i = 0, action_o = 2'b01 (resume at the next instruction).
- R6: On an abort where a flagged, enabled source has its priority bit at 1 (high) and glb_hi_en_i = 1, action_o = 2'b10 (high vector).
- R7: On an abort caused only by low-priority sources (priority bit 0), action_o = 2'b11 (low vector) when glb_hi_en_i = 1 and glb_lo_en_i = 1, and 2'b01 otherwise.
- R8: When high- and low-priority enabled sources are flagged together and glb_hi_en_i = 1, action_o = 2'b10.
- R9: If an enabled interrupt is present in the last counted busy cycle, the write is reported as aborted, with the resume code the interrupt selects.
- R10: Driving rst_n low makes busy_o, done_o, aborted_o and action_o zero at once, without waiting for a clock edge. After rst_n is released, a new write starts normally.
- R11: done_o is never high for two cycles in a row, and the block is idle in the cycle after done_o. Outside done_o, action_o = 2'b00 and aborted_o = 0.
- R12: Enabled, flagged interrupts while the block is idle produce no completion and no busy indication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, released on the clock |
| start_i | input | 1 | One-cycle request to begin a long write |
| irq_flag_i | input | NUM_SRC | Per-source interrupt pending flags |
| irq_en_i | input | NUM_SRC | Per-source interrupt enables |
| irq_hipri_i | input | NUM_SRC | Per-source priority: 1 = high, 0 = low |
| glb_hi_en_i | input | 1 | Global high-priority interrupt enable |
| glb_lo_en_i | input | 1 | Global low-priority interrupt enable |
| busy_o | output | 1 | Write in progress |
| done_o | output | 1 | One-cycle completion strobe |
| aborted_o | output | 1 | Completion was caused by an interrupt (valid with done_o) |
| action_o | output | 2 | Resume code: 00 normal, 01 next instruction, 10 high vector, 11 low vector |

## Verification
A wrong state shows up quickly at the ports. A stuck or skipped state appears as a missing or repeated done_o strobe, or as busy_o lasting a different number of cycles than WRITE_CYCLES, so every write in the bench measures the exact cycle in which done_o rises. A wrong resume decision shows up in action_o in the cycle just after the offending interrupt. A counter that does not clear shows up on the next write as a shortened busy period. The corner cases are the interrupt that coincides with the terminal count, the start pulse that arrives during a write, interrupts during idle, and a reset in the middle of a write.

// File: rtl/lwt_pkg.sv
package lwt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'b00,
    ST_WRITING = 2'b01,
    ST_DONE    = 2'b10
  } lwt_state_e;

  typedef enum logic [1:0] {
    ACT_NORMAL = 2'b00,
    ACT_NEXT   = 2'b01,
    ACT_VEC_HI = 2'b10,
    ACT_VEC_LO = 2'b11
  } lwt_action_e;

endpackage

// File: rtl/lwt_irq_eval.sv
module lwt_irq_eval
  import lwt_pkg::*;
#(
  parameter int NUM_SRC = 8
) (
  input  logic [NUM_SRC-1:0] flag_i,
  input  logic [NUM_SRC-1:0] en_i,
  input  logic [NUM_SRC-1:0] hipri_i,
  input  logic               glb_hi_en_i,
  input  logic               glb_lo_en_i,
  output logic               pending_o,
  output lwt_action_e        action_o
);

  logic [NUM_SRC-1:0] live_hi;
  logic [NUM_SRC-1:0] live_lo;
  logic               any_hi;
  logic               any_lo;

  // Per-source qualification: a source counts only when enabled and flagged.
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign live_hi[g] = flag_i[g] & en_i[g] &  hipri_i[g];
    assign live_lo[g] = flag_i[g] & en_i[g] & ~hipri_i[g];
  end

  assign any_hi    = |live_hi;
  assign any_lo    = |live_lo;
  assign pending_o = any_hi | any_lo;

  // Global enables and priority select only the resume path.
  always_comb begin
    if (any_hi && glb_hi_en_i) begin
      action_o = ACT_VEC_HI;
    end else if (any_lo && glb_hi_en_i && glb_lo_en_i) begin
      action_o = ACT_VEC_LO;
    end else begin
      action_o = ACT_NEXT;
    end
  end

endmodule

// File: rtl/lwt_dur_cnt.sv
module lwt_dur_cnt #(
  parameter int CNT_W        = 16,
  parameter int WRITE_CYCLES = 40000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic terminal_o
);

  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WRITE_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = run_i ? cnt_q + 1'b1 : '0;
    cnt_en = run_i || (cnt_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign terminal_o = run_i && (cnt_q == CNT_LAST);

endmodule

// File: rtl/lwt_fsm.sv
module lwt_fsm
  import lwt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        terminal_i,
  input  logic        abort_i,
  input  lwt_action_e abort_action_i,
  output lwt_state_e  state_o,
  output logic        aborted_o,
  output lwt_action_e action_o
);

  lwt_state_e  state_q, state_d;
  lwt_action_e act_q, act_d;
  logic        abt_q, abt_d;

  always_comb begin
    state_d = state_q;
    act_d   = ACT_NORMAL;
    abt_d   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) state_d = ST_WRITING;
      end
      ST_WRITING: begin
        if (abort_i) begin
          state_d = ST_DONE;
          act_d   = abort_action_i;
          abt_d   = 1'b1;
        end else if (terminal_i) begin
          state_d = ST_DONE;
        end
      end
      ST_DONE: begin
        state_d = ST_IDLE;
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      act_q   <= ACT_NORMAL;
      abt_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      act_q   <= act_d;
      abt_q   <= abt_d;
    end
  end

  assign state_o   = state_q;
  assign aborted_o = abt_q;
  assign action_o  = act_q;

endmodule

// File: rtl/lwt_ctrl.sv
module lwt_ctrl
  import lwt_pkg::*;
#(
  parameter int NUM_SRC      = 8,
  parameter int CNT_W        = 16,
  parameter int WRITE_CYCLES = 40000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [NUM_SRC-1:0] irq_flag_i,
  input  logic [NUM_SRC-1:0] irq_en_i,
  input  logic [NUM_SRC-1:0] irq_hipri_i,
  input  logic               glb_hi_en_i,
  input  logic               glb_lo_en_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               aborted_o,
  output logic [1:0]         action_o
);

  logic [1:0]  rst_pipe_q;
  logic        rst_core_n;
  logic        writing;
  logic        terminal;
  logic        pending;
  lwt_action_e irq_action;
  lwt_action_e fsm_action;
  lwt_state_e  state;
  logic        fsm_aborted;

  // Reset asserts at once, deasserts after two clock edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_core_n = rst_pipe_q[1];

  lwt_irq_eval #(.NUM_SRC(NUM_SRC)) u_eval (
    .flag_i      (irq_flag_i),
    .en_i        (irq_en_i),
    .hipri_i     (irq_hipri_i),
    .glb_hi_en_i (glb_hi_en_i),
    .glb_lo_en_i (glb_lo_en_i),
    .pending_o   (pending),
    .action_o    (irq_action)
  );

  lwt_dur_cnt #(.CNT_W(CNT_W), .WRITE_CYCLES(WRITE_CYCLES)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .run_i      (writing),
    .terminal_o (terminal)
  );

  lwt_fsm u_fsm (
    .clk            (clk),
    .rst_n          (rst_core_n),
    .start_i        (start_i),
    .terminal_i     (terminal),
    .abort_i        (pending),
    .abort_action_i (irq_action),
    .state_o        (state),
    .aborted_o      (fsm_aborted),
    .action_o       (fsm_action)
  );

  assign writing   = (state == ST_WRITING);
  assign busy_o    = writing;
  assign done_o    = (state == ST_DONE);
  assign aborted_o = fsm_aborted;
  assign action_o  = fsm_action;

endmodule

// File: rtl/lwt_ctrl_chk.sv
module lwt_ctrl_chk #(
  parameter int NUM_SRC = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start_i,
  input logic [NUM_SRC-1:0] irq_flag_i,
  input logic [NUM_SRC-1:0] irq_en_i,
  input logic [NUM_SRC-1:0] irq_hipri_i,
  input logic               glb_hi_en_i,
  input logic               glb_lo_en_i,
  input logic               busy_o,
  input logic               done_o,
  input logic               aborted_o,
  input logic [1:0]         action_o
);

  logic any_live;
  logic any_hi;
  logic any_lo;
  assign any_live = |(irq_flag_i & irq_en_i);
  assign any_hi   = |(irq_flag_i & irq_en_i & irq_hipri_i);
  assign any_lo   = |(irq_flag_i & irq_en_i & ~irq_hipri_i);

  AST_START_TO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && !done_o) |=> busy_o); // R1

  AST_NORMAL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !aborted_o) |-> (action_o == 2'b00)); // R2

  AST_ABORT_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && aborted_o) |-> $past(busy_o && any_live)); // R3

  AST_IRQ_ENDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && any_live) |=> (done_o && aborted_o)); // R4

  AST_NO_GLOBAL_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && any_live && !glb_hi_en_i) |=> (action_o == 2'b01)); // R5

  AST_HIGH_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && any_hi && glb_hi_en_i) |=> (action_o == 2'b10)); // R6

  AST_LOW_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && any_lo && !any_hi && glb_hi_en_i && glb_lo_en_i) |=> (action_o == 2'b11)); // R7

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !busy_o)); // R11

  AST_QUIET_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> (action_o == 2'b00 && !aborted_o)); // R11

  AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_o && done_o)); // R11

  AST_IDLE_IGNORES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !done_o && !start_i) |=> (!busy_o && !done_o)); // R12

endmodule

bind lwt_ctrl lwt_ctrl_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk         (clk),
  .rst_n       (rst_core_n),
  .start_i     (start_i),
  .irq_flag_i  (irq_flag_i),
  .irq_en_i    (irq_en_i),
  .irq_hipri_i (irq_hipri_i),
  .glb_hi_en_i (glb_hi_en_i),
  .glb_lo_en_i (glb_lo_en_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .aborted_o   (aborted_o),
  .action_o    (action_o)
);

// File: tb/sim_lwt_ctrl.sv
`timescale 1ns/1ps
module sim_lwt_ctrl;

  localparam int NS = 4;
  localparam int WC = 8;

  typedef struct packed {
    logic [NS-1:0] flag;
    logic [NS-1:0] en;
    logic [NS-1:0] hip;
    logic          gh;
    logic          gl;
    logic          ab;
    logic [1:0]    act;
  } vec_t;

  // flag, en, hip, gh, gl, expected aborted, expected action
  localparam vec_t VECS [10] = '{
    '{4'b0000, 4'b0000, 4'b0000, 1'b1, 1'b1, 1'b0, 2'b00},
    '{4'b1111, 4'b0000, 4'b1010, 1'b1, 1'b1, 1'b0, 2'b00},
    '{4'b0001, 4'b0001, 4'b0001, 1'b1, 1'b0, 1'b1, 2'b10},
    '{4'b0001, 4'b0001, 4'b0001, 1'b0, 1'b1, 1'b1, 2'b01},
    '{4'b0010, 4'b0010, 4'b0000, 1'b1, 1'b1, 1'b1, 2'b11},
    '{4'b0010, 4'b0010, 4'b0000, 1'b1, 1'b0, 1'b1, 2'b01},
    '{4'b0010, 4'b0010, 4'b0000, 1'b0, 1'b1, 1'b1, 2'b01},
    '{4'b0110, 4'b0110, 4'b0100, 1'b1, 1'b1, 1'b1, 2'b10},
    '{4'b1001, 4'b1110, 4'b0001, 1'b1, 1'b1, 1'b1, 2'b11},
    '{4'b0110, 4'b0110, 4'b0100, 1'b0, 1'b0, 1'b1, 2'b01}
  };
  localparam string TAGS [10] = '{"R2", "R3", "R6", "R5", "R7", "R7", "R5", "R8", "R3", "R4"};

  logic          clk;
  logic          rst_n;
  logic          start_i;
  logic [NS-1:0] irq_flag_i;
  logic [NS-1:0] irq_en_i;
  logic [NS-1:0] irq_hipri_i;
  logic          glb_hi_en_i;
  logic          glb_lo_en_i;
  logic          busy_o;
  logic          done_o;
  logic          aborted_o;
  logic [1:0]    action_o;

  int checks;
  int failures;

  lwt_ctrl #(.NUM_SRC(NS), .CNT_W(4), .WRITE_CYCLES(WC)) u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .irq_flag_i  (irq_flag_i),
    .irq_en_i    (irq_en_i),
    .irq_hipri_i (irq_hipri_i),
    .glb_hi_en_i (glb_hi_en_i),
    .glb_lo_en_i (glb_lo_en_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .aborted_o   (aborted_o),
    .action_o    (action_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Runs one write from the idle state; caller is at a negedge.
  // irq_at: cycle after which the interrupt inputs are driven (0 = with start).
  // restart_at: cycle after which a stray start pulse is driven (0 = none).
  task automatic run_write(input vec_t v, input int irq_at, input int restart_at,
                           input string req);
    int  lat;
    bit  early;
    lat   = v.ab ? ((irq_at + 1 < 2) ? 2 : irq_at + 1) : WC + 1;
    early = 1'b0;
    glb_hi_en_i = v.gh;
    glb_lo_en_i = v.gl;
    irq_hipri_i = v.hip;
    if (irq_at == 0) begin
      irq_flag_i = v.flag;
      irq_en_i   = v.en;
    end
    start_i = 1'b1;
    for (int n = 1; n <= lat; n++) begin
      cyc();
      start_i = (restart_at != 0 && n == restart_at);
      if (n == 1) chk(busy_o === 1'b1, "R1", "busy after start", busy_o, 1);
      if (n == irq_at) begin
        irq_flag_i = v.flag;
        irq_en_i   = v.en;
      end
      if (n < lat && done_o !== 1'b0) early = 1'b1;
    end
    chk(!early, req, "done before expected cycle", early, 0);
    chk(done_o === 1'b1, req, "done_o at expected cycle", done_o, 1);
    chk(aborted_o === v.ab, req, "aborted_o", aborted_o, v.ab);
    chk(action_o === v.act, req, "action_o", action_o, v.act);
    start_i = 1'b0;
    cyc();
    chk(done_o === 1'b0 && busy_o === 1'b0, "R11", "idle after done", {done_o, busy_o}, 0);
    chk(action_o === 2'b00 && aborted_o === 1'b0, "R11", "result cleared", {aborted_o, action_o}, 0);
    irq_flag_i = '0;
    irq_en_i   = '0;
  endtask

  initial begin
    #4_000_000;
    failures++;
    $display("FAIL R2 watchdog actual=hung expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    vec_t v;
    checks = 0;
    failures = 0;
    rst_n = 1'b0;
    start_i = 1'b0;
    irq_flag_i = '0;
    irq_en_i = '0;
    irq_hipri_i = '0;
    glb_hi_en_i = 1'b0;
    glb_lo_en_i = 1'b0;
    cyc();
    cyc();
    chk(busy_o === 1'b0 && done_o === 1'b0, "R10", "reset state busy/done", {busy_o, done_o}, 0);
    chk(action_o === 2'b00 && aborted_o === 1'b0, "R10", "reset state result", {aborted_o, action_o}, 0);
    rst_n = 1'b1;
    cyc();
    cyc();
    cyc();

    // Vector table
    for (int i = 0; i < 10; i++) begin
      run_write(VECS[i], (VECS[i].flag != 0) ? 3 : 0, 0, TAGS[i]);
    end

    // Interrupt present together with the start pulse
    run_write(VECS[2], 0, 0, "R4");

    // Interrupt in the last counted cycle: abort wins over terminal count
    v = '{4'b0100, 4'b0100, 4'b0000, 1'b1, 1'b1, 1'b1, 2'b11};
    run_write(v, WC, 0, "R9");
    v = '{4'b0001, 4'b0001, 4'b0001, 1'b0, 1'b0, 1'b1, 2'b01};
    run_write(v, WC, 0, "R9");

    // Stray start during a write does not restart or extend it
    run_write(VECS[0], 0, 4, "R1");

    // Interrupts during idle do nothing
    irq_flag_i = 4'b1111;
    irq_en_i = 4'b1111;
    glb_hi_en_i = 1'b1;
    glb_lo_en_i = 1'b1;
    for (int k = 0; k < 4; k++) begin
      cyc();
      chk(busy_o === 1'b0 && done_o === 1'b0, "R12", "idle with live irq", {busy_o, done_o}, 0);
    end
    irq_flag_i = '0;
    irq_en_i = '0;

    // Reset in the middle of a write
    start_i = 1'b1;
    cyc();
    start_i = 1'b0;
    cyc();
    cyc();
    chk(busy_o === 1'b1, "R10", "busy before reset", busy_o, 1);
    #5;
    rst_n = 1'b0;
    #1;
    chk(busy_o === 1'b0 && done_o === 1'b0, "R10", "async clear on reset", {busy_o, done_o}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 3; k++) begin
      cyc();
      chk(done_o === 1'b0 && busy_o === 1'b0, "R10", "no completion after reset", {busy_o, done_o}, 0);
    end
    run_write(VECS[0], 0, 0, "R10");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule